// File: doc/BRIEF.md
# Banked Stack-Pointer Control Register File

This block keeps a processor's small set of control registers together with the live stack pointer, which is general register 15. Software reaches the control registers through one combinational read port and one write port, both indexed by control-register number. The core's general register file reaches register 15 through its own read/write path. Register 0 is a status word assembled from individual flag bits. Register 1 is a narrow view of the condition flag.

Two stack pointers are kept, one for interrupt mode and one for user mode. The one that matches the current stack mode is the live register 15. The other is held in a banked slot. Control registers 2 and 3 name the two pointers. Each of them resolves either to the live register or to its banked slot, depending on the stack-mode flag. When a status-word write flips the stack mode, the outgoing live value is saved into its bank and the incoming bank is loaded into register 15, all in that one clock edge.

Registers 4 to 6 are plain storage. Indices above 6 are empty.

Top module: `sp_bank_crf`

## Requirements
- R1: After reset every flag is 0, stack mode is user (0), and register 15, both banked pointers and registers 4 to 6 all read as zero.
- R2: Control register 0 packs the flags at fixed bit positions and reads every other bit as zero. The positions are: backup stack mode at 15, backup interrupt enable at 14, backup condition at 8, stack mode at 7, interrupt enable at 6 and condition at 0. A write to register 0 loads each flag from the same bit position.
- R3: Control register 1 reads the condition flag in bit 0 and zero in all other bits. A write to it changes only the condition flag, taking the value from bit 0.
- R4: Control register 2 is the interrupt stack pointer. With stack mode 1 it reads and writes live register 15. With stack mode 0 it reads and writes its own banked slot.
- R5: Control register 3 is the user stack pointer. With stack mode 0 it reads and writes live register 15. With stack mode 1 it reads and writes its own banked slot.
- R6: A register-0 write that moves stack mode from 0 to 1 stores the old register 15 into the user slot and loads register 15 from the interrupt slot, on the same edge.
- R7: A register-0 write that moves stack mode from 1 to 0 stores the old register 15 into the interrupt slot and loads register 15 from the user slot, on the same edge.
- R8: A register-0 write that keeps stack mode unchanged updates the flags and leaves register 15 and both banked slots untouched.
- R9: Control registers 4, 5 and 6 each store and return a full 32-bit value.
- R10: A read of an index above 6 returns zero. A write to such an index changes no register.
- R11: If a register-15 general write coincides with a control-register write that lands on register 15, the control-register write wins. A swap in that cycle uses the register-15 value from before the cycle. A general write that coincides with a control-register write elsewhere still takes effect.
- R12: The general path reads live register 15 combinationally. A general write there is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wr_idx | input | 4 | Control-register write index |
| cr_wr_data | input | 32 | Control-register write value |
| cr_rd_idx | input | 4 | Control-register read index |
| cr_rd_data | output | 32 | Control-register read value (combinational) |
| sp_wr_en | input | 1 | General write strobe for register 15 |
| sp_wr_data | input | 32 | General write value for register 15 |
| sp_rd_data | output | 32 | Live register 15 |

## Verification
The hardest case to reach is a stack-mode flip that coincides with a general write to register 15. In that cycle the swap has to save the pre-cycle value, and the general write has to be dropped. The stimulus first plants distinct values in both banks and in the live register through the aliased indices, so that every move is visible. It then drives a mode-flipping status write and a general write on the same edge. Afterwards it reads the live register and both aliases to confirm where each value went.

// File: rtl/sp_bank_crf.sv
module sp_bank_crf #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_wr_en,
  input  logic [IDX_W-1:0]  cr_wr_idx,
  input  logic [DATA_W-1:0] cr_wr_data,
  input  logic [IDX_W-1:0]  cr_rd_idx,
  output logic [DATA_W-1:0] cr_rd_data,
  input  logic              sp_wr_en,
  input  logic [DATA_W-1:0] sp_wr_data,
  output logic [DATA_W-1:0] sp_rd_data
);
  localparam int BSM_B = 15;
  localparam int BIE_B = 14;
  localparam int BC_B  = 8;
  localparam int SM_B  = 7;
  localparam int IE_B  = 6;
  localparam int C_B   = 0;
  localparam int PLAIN_LO = 4;
  localparam int PLAIN_N  = 3;
  localparam logic [IDX_W-1:0] IX_SR  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_CB  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_ISP = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_USP = IDX_W'(3);

  logic f_bsm, f_bie, f_bc, f_sm, f_ie, f_cond;
  logic [DATA_W-1:0] r15, isp, usp;
  logic [DATA_W-1:0] plain [PLAIN_N];
  logic [DATA_W-1:0] sr_word;

  wire wr_sr     = cr_wr_en && (cr_wr_idx == IX_SR);
  wire wr_cb     = cr_wr_en && (cr_wr_idx == IX_CB);
  wire wr_isp    = cr_wr_en && (cr_wr_idx == IX_ISP);
  wire wr_usp    = cr_wr_en && (cr_wr_idx == IX_USP);
  wire new_sm    = cr_wr_data[SM_B];
  wire mode_flip = wr_sr && (new_sm != f_sm);
  wire cr_on_r15 = mode_flip || (wr_isp && f_sm) || (wr_usp && !f_sm);

  always_comb begin
    sr_word        = '0;
    sr_word[BSM_B] = f_bsm;
    sr_word[BIE_B] = f_bie;
    sr_word[BC_B]  = f_bc;
    sr_word[SM_B]  = f_sm;
    sr_word[IE_B]  = f_ie;
    sr_word[C_B]   = f_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {f_bsm, f_bie, f_bc, f_sm, f_ie, f_cond} <= '0;
    end else if (wr_sr) begin
      f_bsm  <= cr_wr_data[BSM_B];
      f_bie  <= cr_wr_data[BIE_B];
      f_bc   <= cr_wr_data[BC_B];
      f_sm   <= new_sm;
      f_ie   <= cr_wr_data[IE_B];
      f_cond <= cr_wr_data[C_B];
    end else if (wr_cb) begin
      f_cond <= cr_wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          r15 <= '0;
    else if (mode_flip)  r15 <= new_sm ? isp : usp;
    else if (cr_on_r15)  r15 <= cr_wr_data;
    else if (sp_wr_en)   r15 <= sp_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    isp <= '0;
    else if (mode_flip && !new_sm) isp <= r15;
    else if (wr_isp && !f_sm)      isp <= cr_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   usp <= '0;
    else if (mode_flip && new_sm) usp <= r15;
    else if (wr_usp && f_sm)      usp <= cr_wr_data;
  end

  for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
    localparam logic [IDX_W-1:0] IX = IDX_W'(PLAIN_LO + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              plain[g] <= '0;
      else if (cr_wr_en && (cr_wr_idx == IX))  plain[g] <= cr_wr_data;
    end
  end

  always_comb begin
    cr_rd_data = '0;
    if (cr_rd_idx == IX_SR)       cr_rd_data = sr_word;
    else if (cr_rd_idx == IX_CB)  cr_rd_data[0] = f_cond;
    else if (cr_rd_idx == IX_ISP) cr_rd_data = f_sm ? r15 : isp;
    else if (cr_rd_idx == IX_USP) cr_rd_data = f_sm ? usp : r15;
    else begin
      for (int k = 0; k < PLAIN_N; k++)
        if (cr_rd_idx == IDX_W'(PLAIN_LO + k)) cr_rd_data = plain[k];
    end
  end

  assign sp_rd_data = r15;
endmodule

// File: rtl/sp_bank_crf_chk.sv
module sp_bank_crf_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cr_wr_en,
  input logic [IDX_W-1:0]  cr_wr_idx,
  input logic              cr_wr_sm,
  input logic              cr_wr_b0,
  input logic [IDX_W-1:0]  cr_rd_idx,
  input logic [DATA_W-1:0] cr_rd_data,
  input logic              sp_wr_en,
  input logic [DATA_W-1:0] sp_wr_data,
  input logic [DATA_W-1:0] sp_rd_data,
  input logic              f_sm,
  input logic              f_cond,
  input logic [DATA_W-1:0] isp,
  input logic [DATA_W-1:0] usp
);
  localparam logic [DATA_W-1:0] SR_MASK = DATA_W'(32'h0000_C1C1);
  wire sr_wr = cr_wr_en && (cr_wr_idx == IDX_W'(0));

  AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_idx > IDX_W'(6)) |-> (cr_rd_data == '0)); // R10
  AST_SR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_idx == IDX_W'(0)) |-> ((cr_rd_data & ~SR_MASK) == '0)); // R2
  AST_CB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && cr_wr_idx == IDX_W'(1)) |=> (f_cond == $past(cr_wr_b0))); // R3
  AST_SWAP_UP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && cr_wr_sm && !f_sm) |=> (sp_rd_data == $past(isp))); // R6
  AST_SWAP_UP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && cr_wr_sm && !f_sm) |=> (usp == $past(sp_rd_data))); // R6
  AST_SWAP_DN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && !cr_wr_sm && f_sm) |=> (sp_rd_data == $past(usp))); // R7
  AST_SWAP_DN_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && !cr_wr_sm && f_sm) |=> (isp == $past(sp_rd_data))); // R7
  AST_SAME_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && (cr_wr_sm == f_sm) && !sp_wr_en) |=> ($stable(sp_rd_data) && $stable(isp) && $stable(usp))); // R8
  AST_SP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_en && !cr_wr_en) |=> (sp_rd_data == $past(sp_wr_data))); // R12
endmodule

bind sp_bank_crf sp_bank_crf_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx),
  .cr_wr_sm(cr_wr_data[7]), .cr_wr_b0(cr_wr_data[0]),
  .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
  .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd_data(sp_rd_data),
  .f_sm(f_sm), .f_cond(f_cond), .isp(isp), .usp(usp)
);

// File: tb/test_sp_bank_crf.sv
module test_sp_bank_crf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cr_wr_en = 0;
  logic [3:0]  cr_wr_idx = '0;
  logic [31:0] cr_wr_data = '0;
  logic [3:0]  cr_rd_idx = '0;
  logic [31:0] cr_rd_data;
  logic        sp_wr_en = 0;
  logic [31:0] sp_wr_data = '0;
  logic [31:0] sp_rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit          on_sp;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_bank_crf i_sp_bank_crf (
    .clk(clk), .rst_n(rst_n),
    .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx), .cr_wr_data(cr_wr_data),
    .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd_data(sp_rd_data)
  );

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.on_sp ? sp_rd_data : cr_rd_data;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic exp_cr(input logic [3:0] idx, input logic [31:0] v, input string tag);
    item_t it;
    cr_rd_idx = idx;
    it.on_sp = 0; it.exp = v; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_sp(input logic [31:0] v, input string tag);
    item_t it;
    it.on_sp = 1; it.exp = v; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic drive(input bit cw, input logic [3:0] idx, input logic [31:0] d,
                       input bit sw, input logic [31:0] sd);
    cr_wr_en = cw; cr_wr_idx = idx; cr_wr_data = d;
    sp_wr_en = sw; sp_wr_data = sd;
    @(negedge clk);
    cr_wr_en = 0; sp_wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    exp_cr(0, 32'h0, "R1 status word after reset");
    exp_cr(3, 32'h0, "R1 user sp after reset");
    exp_sp(32'h0, "R1 live r15 after reset");
    exp_cr(6, 32'h0, "R1 cr6 after reset");
    rst_n = 1;
    @(negedge clk);

    drive(0, 0, 0, 1, 32'h1111_0000);
    exp_sp(32'h1111_0000, "R12 general write of r15");
    exp_cr(3, 32'h1111_0000, "R5 cr3 aliases r15 in user mode");
    exp_cr(2, 32'h0, "R4 cr2 banked in user mode");

    drive(1, 2, 32'hAAAA_0000, 0, 0);
    exp_cr(2, 32'hAAAA_0000, "R4 cr2 write goes to bank in user mode");
    exp_sp(32'h1111_0000, "R4 r15 untouched by banked cr2 write");

    drive(1, 0, 32'hFFFF_FFFF, 0, 0);
    exp_cr(0, 32'h0000_C1C1, "R2 status word packing");
    exp_sp(32'hAAAA_0000, "R6 r15 loaded from interrupt bank");
    exp_cr(3, 32'h1111_0000, "R6 user bank saved old r15");
    exp_cr(2, 32'hAAAA_0000, "R4 cr2 aliases r15 in interrupt mode");

    exp_cr(1, 32'h1, "R3 cr1 shows condition");
    drive(1, 1, 32'hFFFF_FFFE, 0, 0);
    exp_cr(1, 32'h0, "R3 cr1 write clears condition");
    exp_cr(0, 32'h0000_C1C0, "R3 only condition changed");

    drive(1, 2, 32'h2222_0000, 0, 0);
    exp_sp(32'h2222_0000, "R4 cr2 write lands on r15 in interrupt mode");
    drive(1, 3, 32'h3333_0000, 0, 0);
    exp_cr(3, 32'h3333_0000, "R5 cr3 banked in interrupt mode");
    exp_sp(32'h2222_0000, "R5 r15 untouched by banked cr3 write");

    drive(1, 0, 32'h0000_0081, 0, 0);
    exp_cr(0, 32'h0000_0081, "R8 flags updated without mode change");
    exp_sp(32'h2222_0000, "R8 r15 not swapped");
    exp_cr(3, 32'h3333_0000, "R8 user bank not swapped");

    drive(1, 0, 32'h0, 1, 32'h9999_0000);
    exp_sp(32'h3333_0000, "R11 R7 swap beats general write");
    exp_cr(2, 32'h2222_0000, "R7 interrupt bank saved pre-cycle r15");
    exp_cr(0, 32'h0, "R7 status word after switch down");

    drive(1, 4, 32'h5555_0004, 1, 32'h4444_0000);
    exp_sp(32'h4444_0000, "R11 general write kept when cr write elsewhere");
    exp_cr(4, 32'h5555_0004, "R9 cr4 storage");
    drive(1, 5, 32'h5555_0005, 0, 0);
    drive(1, 6, 32'hDEAD_BEEF, 0, 0);
    exp_cr(5, 32'h5555_0005, "R9 cr5 storage");
    exp_cr(6, 32'hDEAD_BEEF, "R9 cr6 storage");

    drive(1, 7, 32'hFFFF_FFFF, 0, 0);
    drive(1, 15, 32'hFFFF_FFFF, 0, 0);
    exp_cr(7, 32'h0, "R10 index 7 reads zero");
    exp_cr(15, 32'h0, "R10 index 15 reads zero");
    exp_cr(0, 32'h0, "R10 status word unchanged by high write");
    exp_cr(4, 32'h5555_0004, "R10 cr4 unchanged by high write");
    exp_sp(32'h4444_0000, "R10 r15 unchanged by high write");

    drive(1, 3, 32'h7777_0000, 1, 32'h8888_0000);
    exp_sp(32'h7777_0000, "R11 aliased cr3 write beats general write");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule